// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Controller

This block is the digital side of an on-chip analog comparator. It takes the comparator's raw result as one asynchronous bit, synchronizes it, and gives software a control register that selects how three shared port pins are used. The same register returns the live result and holds two event-select bits. A second register holds the interrupt enable. A third register holds the sticky change flag.

Change detection works against a reference latch, not against the previous clock's value. Each software read of the control register copies the current result into that latch. From then on, while the comparator is in one of its two input modes, any difference between the live result and the latch sets the flag. The flag stays set until software clears it. The flag raises an interrupt request when both the local enable and the global enable are set. The wake-up output is combinational from the flag and the local enable, so a sleeping core can be woken without its clock running.

Top module: `cmp_event_ctrl`

## Requirements
- R1: After reset, the control register reads with mode 00 and event-select 00. The enable, the flag, `irq_o`, `wake_o` and all pin controls are 0.
- R2: The control register sits at address 0. Bits 7:6 (event-select) and bits 4:3 (mode) are read/write. Bit 5 returns the synchronized comparator result, which follows `cmp_async_i` after two clock edges. Bits 2:0 always read 0, and writes to bits 5 and 2:0 are ignored.
- R3: Pin control by mode: 00 gives `pin_ana_en_o`=00 and `pin_out_en_o`=0. 01 gives `pin_ana_en_o`=11 and `pin_out_en_o`=0. 10 gives `pin_ana_en_o`=11, `pin_out_en_o`=1 and `pin_out_data_o` equal to the synchronized result. 11 gives `pin_ana_en_o`=11, `pin_out_en_o`=1 and `amp_sel_o`=1. `amp_sel_o` is 0 in every other mode.
- R4: A read of the control register loads the synchronized result into the reference latch. In modes 01 and 10, a difference between the result and the latch sets the flag at the next clock edge.
- R5: The flag sits at bit 0 of the register at address 2. Once set, it stays 1 until software writes that register with bit 0 equal to 0. Writing 1 to that bit has no effect.
- R6: If a clear write and an active mismatch occur in the same cycle, the flag stays 1.
- R7: The interrupt enable is bit 0 of the register at address 1, and the other bits of that register read 0. `irq_o` is 1 exactly when the flag, the enable and `gie_i` are all 1.
- R8: `wake_o` is 1 exactly when the flag and the enable are both 1, whatever the value of `gie_i`.
- R9: In modes 00 and 11 no change event occurs. In mode 00 the reference latch tracks the result every cycle, so moving to an input mode with an unchanged result sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_async_i | input | 1 | Raw comparator result, asynchronous |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request, combinational |
| pin_ana_en_o | output | 2 | Analog input enables for the two input pins |
| pin_out_en_o | output | 1 | Output enable for the third pin |
| pin_out_data_o | output | 1 | Data driven on the third pin |
| amp_sel_o | output | 1 | Amplifier use selected |

## Verification
A reference latch holding a stale value can hide a real edge or create a false one. Either error shows up as a wrong flag bit on the first read of the flag register after the input moves, about three clocks after the input change. A stuck or dropped flag shows at once on `wake_o` and `irq_o`, which are combinational from it. A wrong mode decode shows on the pin controls in the cycle after the control write. The bench therefore moves the input in every mode, clears the flag both with and without a live mismatch, and checks the pins after each mode change.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   localparam int REG_W     = 8;
   localparam int RES_BIT   = 5;
   localparam int MODE_LSB  = 3;
   localparam int EVS_LSB   = 6;
   localparam int EN_BIT    = 0;
   localparam int FLAG_BIT  = 0;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_IN  = 2'b01,
      MODE_OUT = 2'b10,
      MODE_AMP = 2'b11
   } cmp_mode_e;

   function automatic logic mode_detects(cmp_mode_e m);
      return (m == MODE_IN) || (m == MODE_OUT);
   endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cmp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
   import cmp_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 0,
   parameter int EN_ADDR   = 1,
   parameter int FLAG_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic              result_i,
   input  logic              flag_i,
   output logic [REG_W-1:0]  rdata_o,
   output cmp_mode_e         mode_o,
   output logic              en_o,
   output logic              capture_o,
   output logic              clr_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

   if (CTRL_ADDR == EN_ADDR || CTRL_ADDR == FLAG_ADDR || EN_ADDR == FLAG_ADDR) begin : g_bad_map
      $error("cmp_regs: register addresses must differ");
   end
   if ((1 << ADDR_W) <= FLAG_ADDR || (1 << ADDR_W) <= EN_ADDR || (1 << ADDR_W) <= CTRL_ADDR) begin : g_bad_width
      $error("cmp_regs: ADDR_W too narrow for the address map");
   end

   logic      hit_ctrl, hit_en, hit_flag;
   logic [1:0] evsel_q;
   cmp_mode_e mode_q;
   logic      en_q;

   assign hit_ctrl = (addr_i == A_CTRL);
   assign hit_en   = (addr_i == A_EN);
   assign hit_flag = (addr_i == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evsel_q <= 2'b00;
         mode_q  <= MODE_OFF;
         en_q    <= 1'b0;
      end else if (wr_i) begin
         if (hit_ctrl) begin
            evsel_q <= wdata_i[EVS_LSB +: 2];
            mode_q  <= cmp_mode_e'(wdata_i[MODE_LSB +: 2]);
         end
         if (hit_en) en_q <= wdata_i[EN_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl) begin
         rdata_o[EVS_LSB +: 2]  = evsel_q;
         rdata_o[RES_BIT]       = result_i;
         rdata_o[MODE_LSB +: 2] = mode_q;
      end else if (hit_en) begin
         rdata_o[EN_BIT] = en_q;
      end else if (hit_flag) begin
         rdata_o[FLAG_BIT] = flag_i;
      end
   end

   assign mode_o    = mode_q;
   assign en_o      = en_q;
   assign capture_o = rd_i && hit_ctrl;
   assign clr_o     = wr_i && hit_flag && !wdata_i[FLAG_BIT];

   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && hit_ctrl) |=> $stable(mode_q));
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det
   import cmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      result_i,
   input  cmp_mode_e mode_i,
   input  logic      capture_i,
   input  logic      clr_i,
   output logic      flag_o
);
   logic ref_q;
   logic flag_q;
   logic set_ev;

   assign set_ev = mode_detects(mode_i) && (result_i != ref_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ref_q <= 1'b0;
      else if (mode_i == MODE_OFF || capture_i) ref_q <= result_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_i |=> flag_q);
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev && clr_i |=> flag_q);
   p_ref_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> ref_q == $past(result_i));
   p_no_event_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_detects(mode_i) && !flag_q |=> !flag_q);
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
   import cmp_pkg::*;
#(
   parameter bit AMP_DRIVES_PIN = 1'b1
) (
   input  cmp_mode_e  mode_i,
   input  logic       result_i,
   output logic [1:0] ana_en_o,
   output logic       out_en_o,
   output logic       out_data_o,
   output logic       amp_sel_o
);
   logic amp_oe;

   if (AMP_DRIVES_PIN) begin : g_amp_pin
      assign amp_oe = (mode_i == MODE_AMP);
   end else begin : g_amp_nopin
      assign amp_oe = 1'b0;
   end

   assign ana_en_o   = (mode_i == MODE_OFF) ? 2'b00 : 2'b11;
   assign out_en_o   = (mode_i == MODE_OUT) || amp_oe;
   assign out_data_o = (mode_i == MODE_OUT) ? result_i : 1'b0;
   assign amp_sel_o  = (mode_i == MODE_AMP);
endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
   import cmp_pkg::*;
#(
   parameter int ADDR_W         = 2,
   parameter int CTRL_ADDR      = 0,
   parameter int EN_ADDR        = 1,
   parameter int FLAG_ADDR      = 2,
   parameter int SYNC_STAGES    = 2,
   parameter bit AMP_DRIVES_PIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_async_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   input  logic              gie_i,
   output logic              irq_o,
   output logic              wake_o,
   output logic [1:0]        pin_ana_en_o,
   output logic              pin_out_en_o,
   output logic              pin_out_data_o,
   output logic              amp_sel_o
);
   logic      result_s;
   logic      flag_s;
   logic      en_s;
   logic      capture_s;
   logic      clr_s;
   cmp_mode_e mode_s;

   cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_async_i), .q_o(result_s));

   cmp_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .EN_ADDR(EN_ADDR),
              .FLAG_ADDR(FLAG_ADDR)) regs_i (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
      .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .result_i(result_s),
      .flag_i(flag_s), .rdata_o(bus_rdata_o), .mode_o(mode_s),
      .en_o(en_s), .capture_o(capture_s), .clr_o(clr_s));

   cmp_change_det det_i (
      .clk(clk), .rst_n(rst_n), .result_i(result_s), .mode_i(mode_s),
      .capture_i(capture_s), .clr_i(clr_s), .flag_o(flag_s));

   cmp_pin_mux #(.AMP_DRIVES_PIN(AMP_DRIVES_PIN)) pins_i (
      .mode_i(mode_s), .result_i(result_s), .ana_en_o(pin_ana_en_o),
      .out_en_o(pin_out_en_o), .out_data_o(pin_out_data_o),
      .amp_sel_o(amp_sel_o));

   assign wake_o = flag_s & en_s;
   assign irq_o  = wake_o & gie_i;

   p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_i && en_s && flag_s);
   p_out_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_s == MODE_OUT |-> pin_out_en_o && pin_out_data_o == bus_rdata_o[RES_BIT] || bus_addr_i != ADDR_W'(CTRL_ADDR));
   p_wake_no_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_s && en_s |-> wake_o);
endmodule

// File: tb/cmp_event_ctrl_tb_top.sv
module cmp_event_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_in = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       gie = 1'b0;
   logic       irq, wake, oe, odata, amp;
   logic [1:0] ana;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct { logic [7:0] exp; string tag; } rd_item_t;
   rd_item_t exp_q[$];

   always #10 clk = ~clk;

   cmp_event_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp_in), .bus_addr_i(addr),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .gie_i(gie), .irq_o(irq), .wake_o(wake), .pin_ana_en_o(ana),
      .pin_out_en_o(oe), .pin_out_data_o(odata), .amp_sel_o(amp));

   // monitor: pops expected read data and compares
   always @(negedge clk) begin
      if (rd) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: read without expectation, got %h", rdata);
         end else begin
            rd_item_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: read got %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(posedge clk); #2;
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #2;
      wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, logic [7:0] e, string tag);
      @(posedge clk); #2;
      exp_q.push_back('{exp: e, tag: tag});
      addr = a; rd = 1'b1;
      @(posedge clk); #2;
      rd = 1'b0;
   endtask

   task automatic check(logic [7:0] act, logic [7:0] e, string tag);
      n_checks++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   function automatic logic [7:0] pins();
      return {3'b0, amp, odata, oe, ana};
   endfunction

   initial begin
      #200000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      check({6'b0, irq, wake}, 8'h00, "R1 irq/wake");
      check(pins(), 8'h00, "R1 pins");
      bus_read(2'd0, 8'h00, "R1 ctrl");
      bus_read(2'd1, 8'h00, "R1 enable");
      bus_read(2'd2, 8'h00, "R1 flag");

      // R2 / R3 mode 01
      bus_write(2'd0, 8'hC8);
      bus_read(2'd0, 8'hC8, "R2 ctrl rw");
      check(pins(), 8'h03, "R3 mode 01 pins");

      // R4 change in mode 01
      cmp_in = 1'b1;
      tick(4);
      bus_read(2'd2, 8'h01, "R4 flag set by change");
      check({7'b0, wake}, 8'h00, "R8 wake needs enable");
      bus_read(2'd0, 8'hE8, "R2 result bit");
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, 8'h00, "R5 clear after capture");
      bus_write(2'd2, 8'h01);
      bus_read(2'd2, 8'h00, "R5 write one ignored");

      // R7 / R8 enable and irq
      bus_write(2'd1, 8'hFF);
      bus_read(2'd1, 8'h01, "R7 enable readback");
      cmp_in = 1'b0;
      tick(4);
      check({6'b0, irq, wake}, 8'h01, "R8 wake without gie");
      gie = 1'b1;
      #1;
      check({7'b0, irq}, 8'h01, "R7 irq with gie");
      tick(3);
      bus_read(2'd2, 8'h01, "R5 flag sticky");
      // R6 clear during live mismatch (ref=1, result=0)
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, 8'h01, "R6 set wins over clear");
      bus_read(2'd0, 8'hC8, "R4 capture result 0");
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, 8'h00, "R5 clear no mismatch");
      check({6'b0, irq, wake}, 8'h00, "R7 irq drops");

      // mode 10
      bus_write(2'd0, 8'h10);
      check(pins(), 8'h07, "R3 mode 10 pins result 0");
      cmp_in = 1'b1;
      tick(3);
      check(pins(), 8'h0F, "R3 mode 10 pin data follows");
      tick(1);
      bus_read(2'd2, 8'h01, "R4 flag in mode 10");
      bus_read(2'd0, 8'h30, "R2 ctrl mode 10");
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, 8'h00, "R5 clear mode 10");

      // mode 11: no events
      bus_write(2'd0, 8'h18);
      check(pins(), 8'h17, "R3 mode 11 pins");
      cmp_in = 1'b0;
      tick(5);
      bus_read(2'd2, 8'h00, "R9 no event mode 11");

      // mode 00: no events, reference tracks
      bus_write(2'd0, 8'h00);
      check(pins(), 8'h00, "R3 mode 00 pins");
      cmp_in = 1'b1;
      tick(5);
      bus_read(2'd2, 8'h00, "R9 no event mode 00");
      bus_write(2'd0, 8'h08);
      tick(3);
      bus_read(2'd2, 8'h00, "R9 reference tracked in mode 00");
      check({7'b0, wake}, 8'h00, "R9 no wake");

      // R2 read-only bits
      bus_write(2'd0, 8'h5F);
      bus_read(2'd0, 8'h78, "R2 low bits read zero");
      cmp_in = 1'b0;
      tick(4);
      bus_write(2'd0, 8'h28);
      bus_read(2'd0, 8'h08, "R2 result bit not writable");

      tick(2);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: %0d reads unmatched, expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule